// File: doc/BRIEF.md
# Delayed-Scaling Amax History Tracker

This block chooses, once per training step, the absolute maximum (amax) that a tensor's low-precision cast should be scaled against. It also produces the matching scale factor. Each step presents one observed amax as an IEEE-754 single-precision word, qualified by a one-cycle step strobe. For a configurable number of accepted steps after reset or restart, the block is in a warm-up phase and forwards the amax of the current step unchanged, which gives just-in-time scaling. After that it switches permanently to delayed scaling. In this mode the selected amax is the mean of the amax values kept from earlier steps, and the current step's value only enters the history for later steps.

The history is a ring of the most recent accepted steps. Each entry is held as an unsigned 16.16 fixed-point magnitude, and a running sum is updated by adding the new entry and subtracting the one it replaces. The mean is taken over the entries actually present. The scale is the selected amax divided by the target format's largest finite value, which defaults to 448. The division is done as a multiplication by a precomputed reciprocal. A word that is NaN or infinite is kept out of the history and latches an error flag. A synchronous restart input returns the block to its post-reset condition.

Top module: `amax_delay_tracker`

## Requirements
- R1: After reset, `amax_sel`, `scale_out`, `delayed_mode` and `bad_input` are all zero.
- R2: An accepted step whose index is below WARMUP_STEPS updates `amax_sel` to the input word with bit 31 (sign) cleared. The index counts accepted steps since reset or restart, starting at 0. The update is visible one cycle after the strobe.
- R3: An accepted step whose index is WARMUP_STEPS or higher updates `amax_sel` one cycle after the strobe. The value is the FP32 encoding, with the mantissa truncated, of floor(S/C)/65536. S is the sum of the stored 16.16 entries and C is their count, both taken before the current step is stored.
- R4: `delayed_mode` is 0 after every accepted step with index below WARMUP_STEPS and 1 after every later one. Once it is 1, it stays 1 until restart or reset.
- R5: The history keeps only the HIST_DEPTH most recently accepted steps. Each new entry replaces the oldest one.
- R6: While fewer than HIST_DEPTH steps are stored, the delayed mean divides by the number of stored entries, not by HIST_DEPTH.
- R7: A stored entry is the input magnitude times 65536, truncated. A magnitude of 65536 or more is stored as 0xFFFFFFFF, and a zero or subnormal exponent field stores 0.
- R8: Two cycles after a strobe, `scale_out` equals `amax_sel`/FMT_MAX within a relative error of 2^-21. It is exactly 0 when `amax_sel` is 0.
- R9: A strobed word whose exponent field (bits 30:23) is all ones is not stored and does not advance the step index. It leaves `amax_sel` and `delayed_mode` unchanged and sets `bad_input`, which stays set until restart or reset.
- R10: `restart` empties the history, clears the step index, and zeroes `amax_sel`, `scale_out`, `delayed_mode` and `bad_input`. It takes priority over a strobe in the same cycle.
- R11: In a cycle with no strobe and no restart, `amax_sel` and `delayed_mode` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous restart of history, step index and flags |
| step_vld | input | 1 | One-cycle strobe marking a new step's amax |
| amax_obs | input | 32 | Observed amax of the step, FP32 |
| amax_sel | output | 32 | Selected amax, FP32, sign always 0 |
| scale_out | output | 32 | Selected amax divided by FMT_MAX, FP32 |
| delayed_mode | output | 1 | 1 when the last accepted step used the history mean |
| bad_input | output | 1 | Sticky flag for a NaN or infinite input |

## Verification
`amax_sel`, `delayed_mode` and `bad_input` change at the clock edge that samples the strobe. `scale_out` follows one edge later, because it is registered from the selected amax. The bench drives each strobe for exactly one cycle from a falling edge. It checks the selection, mode and error at the next falling edge. At the falling edge after that, with the strobe low, it checks the scale and confirms that the selection held. Expected means come from a queue model of the 16.16 entries, using integer floor division and a truncating conversion to FP32.

// File: rtl/amaxhist_pkg.sv
package amaxhist_pkg;

    localparam int FP_BIAS  = 127;
    localparam int FP_MAN_W = 23;

    typedef struct packed {
        logic       sgn;
        logic [7:0] exp;
        logic [22:0] man;
    } fp32_t;

    typedef enum logic {
        MODE_JIT     = 1'b0,
        MODE_DELAYED = 1'b1
    } scale_mode_e;

    // NaN or infinity: exponent field saturated
    function automatic logic fp_nonfinite(input fp32_t v);
        return &v.exp;
    endfunction

    function automatic fp32_t fp_abs(input fp32_t v);
        fp32_t r;
        r     = v;
        r.sgn = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/amaxhist_fp2fix.sv
module amaxhist_fp2fix
    import amaxhist_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic [30:0]             mag_in,
    output logic [INT_W+FRAC_W-1:0] fix_out
);
    localparam int FIX_W  = INT_W + FRAC_W;
    localparam int WIDE_W = FIX_W + 24;
    localparam int SAT_E  = FP_BIAS + INT_W;

    logic [7:0]  e_fld;
    logic [23:0] mant;
    int          sh;

    assign e_fld = mag_in[30:23];
    assign mant  = {1'b1, mag_in[22:0]};

    always_comb begin
        sh = int'(e_fld) - (FP_BIAS + FP_MAN_W) + FRAC_W;
        if (e_fld == 8'd0) begin
            fix_out = '0;
        end else if (int'(e_fld) >= SAT_E) begin
            fix_out = '1;
        end else if (sh >= 0) begin
            fix_out = FIX_W'(WIDE_W'(mant) << sh);
        end else if (sh > -25) begin
            fix_out = FIX_W'(mant >> (-sh));
        end else begin
            fix_out = '0;
        end
    end
endmodule

// File: rtl/amaxhist_ring.sv
module amaxhist_ring #(
    parameter int DEPTH = 16,
    parameter int FIX_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 clear,
    input  logic                                 wr_en,
    input  logic [FIX_W-1:0]                     wr_data,
    output logic [FIX_W+$clog2(DEPTH+1)-1:0]     sum_out,
    output logic [$clog2(DEPTH+1)-1:0]           cnt_out
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SUM_W = FIX_W + CNT_W;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [FIX_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] fill;
    logic [SUM_W-1:0] run_sum;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
            wr_ptr  <= '0;
            fill    <= '0;
            run_sum <= '0;
        end else if (wr_en) begin
            slot[wr_ptr] <= wr_data;
            // an empty slot holds zero, so the same update serves fill and eviction
            run_sum <= run_sum - SUM_W'(slot[wr_ptr]) + SUM_W'(wr_data);
            wr_ptr  <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (fill != CNT_W'(DEPTH)) fill <= fill + 1'b1;
        end
    end

    assign sum_out = run_sum;
    assign cnt_out = fill;

    // R5: never more entries than slots
    p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R6: the divisor grows by one per write until the ring is full
    p_fill_grows_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clear && fill < CNT_W'(DEPTH)) |=> fill == $past(fill) + 1'b1);

    // R10: a cleared ring carries no residual sum
    p_empty_sum_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> (fill == '0 && run_sum == '0));
endmodule

// File: rtl/amaxhist_avg.sv
module amaxhist_avg
    import amaxhist_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic [INT_W+FRAC_W+$clog2(DEPTH+1)-1:0] sum_in,
    input  logic [$clog2(DEPTH+1)-1:0]              cnt_in,
    output fp32_t                                   avg_fp
);
    localparam int FIX_W  = INT_W + FRAC_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int SUM_W  = FIX_W + CNT_W;
    // 2^RB exceeds max_sum * max_count, so the scaled product floors exactly
    localparam int RB     = SUM_W + CNT_W;
    localparam int PROD_W = SUM_W + RB + 1;
    localparam int WIDE_W = FIX_W + 24;

    function automatic logic [RB:0] recip_const(input int n);
        logic [RB+1:0] num;
        num = ((RB+2)'(1) << RB) + (RB+2)'(n - 1);
        return (RB+1)'(num / (RB+2)'(n));
    endfunction

    logic [RB:0] recip_rom [DEPTH+1];

    for (genvar g = 0; g <= DEPTH; g++) begin : g_recip
        if (g == 0) begin : g_none
            assign recip_rom[g] = '0;
        end else begin : g_val
            assign recip_rom[g] = recip_const(g);
        end
    end

    logic [PROD_W-1:0] prod;
    logic [FIX_W-1:0]  avg_fix;
    int                msb;

    assign prod    = PROD_W'(sum_in) * PROD_W'(recip_rom[cnt_in]);
    assign avg_fix = FIX_W'(prod >> RB);

    always_comb begin
        msb = 0;
        for (int i = 0; i < FIX_W; i++) begin
            if (avg_fix[i]) msb = i;
        end
        avg_fp = '0;
        if (avg_fix != '0) begin
            avg_fp.exp = 8'(FP_BIAS + msb - FRAC_W);
            if (msb >= FP_MAN_W) begin
                avg_fp.man = 23'(avg_fix >> (msb - FP_MAN_W));
            end else begin
                avg_fp.man = 23'(WIDE_W'(avg_fix) << (FP_MAN_W - msb));
            end
        end
    end
endmodule

// File: rtl/amaxhist_scale.sv
module amaxhist_scale
    import amaxhist_pkg::*;
#(
    parameter int FMT_MAX = 448
) (
    input  logic [30:0] mag_in,
    output fp32_t       scale_fp
);
    // FMT_MAX lies in (2^(KSH-1), 2^KSH], so the reciprocal mantissa is in [2^23, 2^24)
    localparam int          KSH = $clog2(FMT_MAX);
    localparam logic [23:0] RCP_MAN =
        24'(((64'(1) << (FP_MAN_W + KSH)) + 64'(FMT_MAX / 2)) / 64'(FMT_MAX));

    logic [7:0]  e_fld;
    logic [47:0] prod;
    int          e_out;

    assign e_fld = mag_in[30:23];
    assign prod  = 48'({1'b1, mag_in[22:0]}) * 48'(RCP_MAN);

    always_comb begin
        e_out    = int'(e_fld) - KSH + (prod[47] ? 1 : 0);
        scale_fp = '0;
        if (e_fld != 8'd0 && e_out > 0) begin
            scale_fp.exp = 8'(e_out);
            scale_fp.man = prod[47] ? 23'(prod >> 24) : 23'(prod >> 23);
        end
    end
endmodule

// File: rtl/amax_delay_tracker.sv
module amax_delay_tracker
    import amaxhist_pkg::*;
#(
    parameter int HIST_DEPTH   = 16,
    parameter int WARMUP_STEPS = 1000,
    parameter int FMT_MAX      = 448,
    parameter int INT_W        = 16,
    parameter int FRAC_W       = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        step_vld,
    input  logic [31:0] amax_obs,
    output logic [31:0] amax_sel,
    output logic [31:0] scale_out,
    output logic        delayed_mode,
    output logic        bad_input
);
    localparam int FIX_W  = INT_W + FRAC_W;
    localparam int CNT_W  = $clog2(HIST_DEPTH + 1);
    localparam int SUM_W  = FIX_W + CNT_W;
    localparam int STEP_W = $clog2(WARMUP_STEPS + 1);

    fp32_t            obs_fp;
    logic             obs_bad;
    logic             accept;
    logic             in_warmup;
    logic [FIX_W-1:0] obs_fix;
    logic [SUM_W-1:0] hist_sum;
    logic [CNT_W-1:0] hist_cnt;
    fp32_t            hist_mean;
    fp32_t            scale_d;

    fp32_t            sel_q;
    fp32_t            scale_q;
    scale_mode_e      mode_q;
    logic             err_q;
    logic [STEP_W-1:0] step_idx;

    assign obs_fp    = amax_obs;
    assign obs_bad   = fp_nonfinite(obs_fp);
    assign accept    = step_vld && !obs_bad && !restart;
    assign in_warmup = step_idx < STEP_W'(WARMUP_STEPS);

    amaxhist_fp2fix #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_fp2fix (
        .mag_in  (amax_obs[30:0]),
        .fix_out (obs_fix)
    );

    amaxhist_ring #(
        .DEPTH (HIST_DEPTH),
        .FIX_W (FIX_W)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .clear   (restart),
        .wr_en   (accept),
        .wr_data (obs_fix),
        .sum_out (hist_sum),
        .cnt_out (hist_cnt)
    );

    amaxhist_avg #(
        .DEPTH  (HIST_DEPTH),
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_avg (
        .sum_in (hist_sum),
        .cnt_in (hist_cnt),
        .avg_fp (hist_mean)
    );

    amaxhist_scale #(
        .FMT_MAX (FMT_MAX)
    ) u_scale (
        .mag_in   (sel_q[30:0]),
        .scale_fp (scale_d)
    );

    // selection stage: the mean reflects earlier steps only
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sel_q    <= '0;
            mode_q   <= MODE_JIT;
            err_q    <= 1'b0;
            step_idx <= '0;
        end else begin
            if (step_vld && obs_bad) err_q <= 1'b1;
            if (accept) begin
                if (in_warmup) begin
                    sel_q    <= fp_abs(obs_fp);
                    mode_q   <= MODE_JIT;
                    step_idx <= step_idx + 1'b1;
                end else begin
                    sel_q  <= hist_mean;
                    mode_q <= MODE_DELAYED;
                end
            end
        end
    end

    // scale stage: one register after the selection
    always_ff @(posedge clk) begin
        if (rst || restart) scale_q <= '0;
        else                scale_q <= scale_d;
    end

    assign amax_sel     = sel_q;
    assign scale_out    = scale_q;
    assign delayed_mode = (mode_q == MODE_DELAYED);
    assign bad_input    = err_q;

    // R2: the selected amax never carries a sign
    p_no_sign_r2: assert property (@(posedge clk) disable iff (rst)
        !amax_sel[31]);

    // R4: delayed scaling is permanent until restart
    p_mode_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (delayed_mode && !restart) |=> delayed_mode);

    // R9: error flag sticks, and a rejected word leaves the selection alone
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (bad_input && !restart) |=> bad_input);
    p_bad_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (step_vld && obs_bad && !restart) |=> ($stable(amax_sel) && bad_input));

    // R10: restart returns outputs to their cleared state
    p_restart_clear_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (amax_sel == '0 && !delayed_mode && !bad_input));

    // R11: no strobe, no change
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!step_vld && !restart) |=> ($stable(amax_sel) && $stable(delayed_mode)));

    // R8: zero amax gives zero scale on the following cycle
    p_scale_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (amax_sel == '0) |=> (scale_out == '0));
endmodule

// File: tb/test_amax_delay_tracker.sv
`timescale 1ns/1ps
module test_amax_delay_tracker;
    localparam int DEPTH = 8;
    localparam int WARM  = 5;
    localparam int FMAX  = 448;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic        step_vld = 1'b0;
    logic [31:0] amax_obs = '0;
    logic [31:0] amax_sel;
    logic [31:0] scale_out;
    logic        delayed_mode;
    logic        bad_input;

    always #2.5 clk = ~clk;

    amax_delay_tracker #(
        .HIST_DEPTH   (DEPTH),
        .WARMUP_STEPS (WARM),
        .FMT_MAX      (FMAX),
        .INT_W        (16),
        .FRAC_W       (16)
    ) i_amax_delay_tracker (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .step_vld     (step_vld),
        .amax_obs     (amax_obs),
        .amax_sel     (amax_sel),
        .scale_out    (scale_out),
        .delayed_mode (delayed_mode),
        .bad_input    (bad_input)
    );

    int n_checks = 0;
    int n_errs   = 0;

    longint      hist[$];
    int          acc = 0;
    bit          evicted = 1'b0;
    logic [31:0] exp_sel = '0;
    logic        exp_mode = 1'b0;
    logic        exp_err = 1'b0;

    function automatic real to_real(input logic [31:0] f);
        if (f[30:23] == 8'd0) return 0.0;
        return $bitstoreal({1'b0, 11'(int'(f[30:23]) - 127 + 1023), f[22:0], 29'b0});
    endfunction

    // exact for short values; drops low bits (truncation) otherwise
    function automatic logic [31:0] to_f32(input real r);
        logic [63:0] b;
        if (r == 0.0) return 32'h0;
        b = $realtobits(r);
        return {b[63], 8'(int'(b[62:52]) - 1023 + 127), b[51:29]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input string act, input string expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %s expected %s", req, what, act, expv);
        end
    endtask

    task automatic check_scale(input string req);
        real e, a, tol;
        bit  ok;
        e   = to_real(exp_sel) / real'(FMAX);
        a   = to_real(scale_out);
        tol = e / 2097152.0;
        if (exp_sel[30:0] == '0) ok = (scale_out == 32'h0);
        else ok = ((a - e) <= tol) && ((e - a) <= tol);
        check(ok, req, "scale", $sformatf("%g", a), $sformatf("%g", e));
    endtask

    // one strobe, then one idle cycle
    task automatic step_in(input logic [31:0] bits, input string tag_ovr);
        bit     bad;
        real    mag;
        longint fx, s;
        int     c;
        string  tag;
        logic [31:0] prev_sel;
        bad = &bits[30:23];
        tag = "R9";
        if (bad) begin
            exp_err = 1'b1;
        end else begin
            mag = to_real(bits);
            if (mag * 65536.0 >= 4294967296.0) fx = 64'hFFFF_FFFF;
            else fx = longint'($floor(mag * 65536.0));
            if (acc < WARM) begin
                exp_sel  = {1'b0, bits[30:0]};
                exp_mode = 1'b0;
                acc++;
                tag = "R2";
            end else begin
                s = 0;
                foreach (hist[i]) s += hist[i];
                c = hist.size();
                exp_sel  = to_f32(real'(s / c) / 65536.0);
                exp_mode = 1'b1;
                tag = (c < DEPTH) ? "R6" : (evicted ? "R5" : "R3");
            end
            hist.push_back(fx);
            if (hist.size() > DEPTH) begin
                void'(hist.pop_front());
                evicted = 1'b1;
            end
        end
        if (tag_ovr != "") tag = tag_ovr;
        step_vld = 1'b1;
        amax_obs = bits;
        @(negedge clk);
        step_vld = 1'b0;
        check(amax_sel == exp_sel, tag, "amax_sel",
              $sformatf("%h", amax_sel), $sformatf("%h", exp_sel));
        check(delayed_mode == exp_mode, "R4", "delayed_mode",
              $sformatf("%0b", delayed_mode), $sformatf("%0b", exp_mode));
        check(bad_input == exp_err, "R9", "bad_input",
              $sformatf("%0b", bad_input), $sformatf("%0b", exp_err));
        prev_sel = amax_sel;
        @(negedge clk);
        check(amax_sel == prev_sel, "R11", "amax_sel hold",
              $sformatf("%h", amax_sel), $sformatf("%h", prev_sel));
        check_scale("R8");
    endtask

    task automatic do_restart(input logic [31:0] bits);
        restart  = 1'b1;
        step_vld = 1'b1;
        amax_obs = bits;
        @(negedge clk);
        restart  = 1'b0;
        step_vld = 1'b0;
        hist.delete();
        acc = 0; evicted = 1'b0;
        exp_sel = '0; exp_mode = 1'b0; exp_err = 1'b0;
        check(amax_sel == 32'h0, "R10", "amax_sel", $sformatf("%h", amax_sel), "0");
        check(!delayed_mode && !bad_input, "R10", "flags",
              $sformatf("%0b%0b", delayed_mode, bad_input), "00");
        @(negedge clk);
        check(scale_out == 32'h0, "R10", "scale", $sformatf("%h", scale_out), "0");
    endtask

    initial begin
        #500000;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(amax_sel == 0 && scale_out == 0, "R1", "outputs",
              $sformatf("%h/%h", amax_sel, scale_out), "0/0");
        check(!delayed_mode && !bad_input, "R1", "flags",
              $sformatf("%0b%0b", delayed_mode, bad_input), "00");

        // warm-up with a NaN that must not count as a step (R9)
        step_in(to_f32(1.5), "");
        step_in(to_f32(-2.25), "");
        step_in(32'h7FC0_0000, "");
        step_in(to_f32(3.0), "");
        step_in(to_f32(0.25), "");
        step_in(to_f32(100.0), "");
        // delayed: partial history (R6), full (R3), then eviction (R5)
        step_in(to_f32(7.75), "");
        step_in(to_f32(12.0), "");
        step_in(to_f32(0.5), "");
        step_in(to_f32(4.0), "");
        step_in(32'h7F80_0000, "");
        step_in(to_f32(9.25), "");
        step_in(32'hFF80_0000, "");
        step_in(to_f32(-33.5), "");
        step_in(to_f32(0.0), "");

        // R10: restart wins over a simultaneous strobe
        do_restart(to_f32(55.0));

        // R7: saturating entries
        for (int i = 0; i < WARM; i++) step_in(to_f32(70000.0), "");
        step_in(to_f32(1.0), "R7");
        step_in(to_f32(65536.0), "R7");
        step_in(to_f32(2.0), "");

        // sweep with periodic restarts
        for (int n = 0; n < 400; n++) begin
            if (n % 60 == 0) do_restart(to_f32(1.0));
            seed = seed * 32'd1664525 + 32'd1013904223;
            if (seed[31:28] == 4'hF) step_in(32'h7FC0_0001, "");
            else step_in(to_f32((seed[30] && seed[29] ? -1.0 : 1.0)
                                * real'(seed[25:8]) / 4.0), "");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule